// File: doc/BRIEF.md
# Two-way coherence message channel with response priority

This block carries coherence traffic between a group of child caches and their single parent. Messages flow in both directions. Each direction has two classes, requests and responses, and each class has its own lane. In the upward direction every child owns one small FIFO per class. A round-robin arbiter for each class merges those FIFOs into one output toward the parent. In the downward direction the parent writes into one FIFO per class per child, and the choice of FIFO comes from the destination field of the message.

Each destination port presents one message at a time, tagged with its class. A queued response is always offered ahead of any request. The consumer has one ready per class. It can therefore stall requests indefinitely while responses keep draining past them. Once a response is queued for a destination, every request to that destination waits until it is delivered. So no request can overtake an earlier response to the same address.

Top module: `mc_channel`

## Requirements
- R1: During and right after reset no output port is valid, and every upward input reports ready.
- R2: Messages from one child in one class reach the parent in the order they were accepted, with none lost or duplicated.
- R3: The parent port marks its message as a response (`par_is_rsp`=1) whenever any child response is queued. A request is offered only when no child response is queued, so a request never passes an earlier response.
- R4: Within one class, the upward merge grants children round-robin, starting after the child last served in that class. After reset, child 0 has first priority in each class.
- R5: An input message is taken on a cycle with valid and ready both high. Ready is low exactly when the target FIFO holds DEPTH entries.
- R6: A downward message goes to the child numbered by bits 27:26 of the 30-bit message. The full layout is {src[29:28], dst[27:26], state[25:24], addr[23:16], data[15:0]}. A destination number of N_CHILD or above is never accepted.
- R7: Messages from the parent to one child in one class arrive in acceptance order.
- R8: A child port offers a request only when no response is queued for that child.
- R9: An offered message leaves when the ready of its own class is high. The ready of the other class has no effect on it, so responses flow while request readies are held low.
- R10: A stalled child port does not hold up deliveries to other children.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | N_CHILD | Request valid, one bit per child |
| up_req_msg | input | N_CHILD*30 | Request message per child, child i at [i*30 +: 30] |
| up_req_ready | output | N_CHILD | Request FIFO of child has room |
| up_rsp_valid | input | N_CHILD | Response valid per child |
| up_rsp_msg | input | N_CHILD*30 | Response message per child |
| up_rsp_ready | output | N_CHILD | Response FIFO of child has room |
| par_valid | output | 1 | Message offered to parent |
| par_is_rsp | output | 1 | Offered message is a response |
| par_msg | output | 30 | Offered message |
| par_req_ready | input | 1 | Parent takes a request |
| par_rsp_ready | input | 1 | Parent takes a response |
| dn_req_valid | input | 1 | Parent request valid |
| dn_req_msg | input | 30 | Parent request, routed by dst |
| dn_req_ready | output | 1 | Request taken |
| dn_rsp_valid | input | 1 | Parent response valid |
| dn_rsp_msg | input | 30 | Parent response, routed by dst |
| dn_rsp_ready | output | 1 | Response taken |
| ch_valid | output | N_CHILD | Message offered to child |
| ch_is_rsp | output | N_CHILD | Offered message is a response |
| ch_msg | output | N_CHILD*30 | Offered message per child |
| ch_req_ready | input | N_CHILD | Child takes a request |
| ch_rsp_ready | input | N_CHILD | Child takes a response |

## Verification
Fully random traffic with random readies exercises ordering and the round-robin rotation together. Every output and ready is compared on each clock with a queue model. A stretch with every request ready low and every response ready high separates true lane independence from a shared head-of-line queue. The reverse stretch shows that requests wait while responses are pending. A saturated request-only stretch tells a fair rotation apart from fixed priority by counting grants per child. A stretch with one child's readies held low tells per-destination queues apart from a shared downward buffer.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int ID_W    = 2;
  localparam int ST_W    = 2;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int DST_LSB = ST_W + ADDR_W + DATA_W;
  localparam int MSG_W   = 2 * ID_W + DST_LSB;

  function automatic logic [ID_W-1:0] msg_dst(input logic [MSG_W-1:0] m);
    return m[DST_LSB +: ID_W];
  endfunction
endpackage

// File: rtl/mc_fifo.sv
module mc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         pop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wrap_inc(wp);
      if (pop)  rp <= wrap_inc(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/mc_rr_arb.sv
module mc_rr_arb #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [IW-1:0] last;

  function automatic logic [IW-1:0] rr_pick(input logic [N-1:0] r, input logic [IW-1:0] prev);
    logic [IW-1:0] sel;
    logic          found;
    sel   = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(prev) + k) % N;
      if (!found && r[c]) begin
        sel   = IW'(c);
        found = 1'b1;
      end
    end
    return sel;
  endfunction

  assign any = |req;
  assign idx = rr_pick(req, last);

  always_ff @(posedge clk) begin
    if (!rst_n)   last <= IW'(N - 1);
    else if (adv) last <= idx;
  end
endmodule

// File: rtl/mc_lane_sel.sv
module mc_lane_sel #(
  parameter int W = 8
) (
  input  logic         rsp_have,
  input  logic         req_have,
  input  logic [W-1:0] rsp_msg,
  input  logic [W-1:0] req_msg,
  input  logic         rsp_ready,
  input  logic         req_ready,
  output logic         out_valid,
  output logic         out_is_rsp,
  output logic [W-1:0] out_msg,
  output logic         rsp_take,
  output logic         req_take
);
  assign out_valid  = rsp_have || req_have;
  assign out_is_rsp = rsp_have;
  assign out_msg    = rsp_have ? rsp_msg : req_msg;
  assign rsp_take   = rsp_have && rsp_ready;
  assign req_take   = !rsp_have && req_have && req_ready;
endmodule

// File: rtl/mc_merge.sv
module mc_merge #(
  parameter int N     = 3,
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_valid,
  input  logic [N*W-1:0] req_msg,
  output logic [N-1:0]   req_ready,
  input  logic [N-1:0]   rsp_valid,
  input  logic [N*W-1:0] rsp_msg,
  output logic [N-1:0]   rsp_ready,
  output logic           out_valid,
  output logic           out_is_rsp,
  output logic [W-1:0]   out_msg,
  input  logic           out_req_ready,
  input  logic           out_rsp_ready,
  output logic           rsp_pending,
  output logic [N-1:0]   pop_vec
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  rq_have, rs_have, rq_pop, rs_pop;
  logic [W-1:0]  rq_head [N];
  logic [W-1:0]  rs_head [N];
  logic [IW-1:0] rq_idx, rs_idx;
  logic          rq_any, rs_any, req_take, rsp_take;

  for (genvar i = 0; i < N; i++) begin : g_src
    mc_fifo #(.W(W), .DEPTH(DEPTH)) u_req_q (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid[i]), .in_ready(req_ready[i]), .in_data(req_msg[i*W +: W]),
      .out_valid(rq_have[i]), .out_data(rq_head[i]), .pop(rq_pop[i]));
    mc_fifo #(.W(W), .DEPTH(DEPTH)) u_rsp_q (
      .clk(clk), .rst_n(rst_n),
      .in_valid(rsp_valid[i]), .in_ready(rsp_ready[i]), .in_data(rsp_msg[i*W +: W]),
      .out_valid(rs_have[i]), .out_data(rs_head[i]), .pop(rs_pop[i]));
    assign rq_pop[i] = req_take && (rq_idx == IW'(i));
    assign rs_pop[i] = rsp_take && (rs_idx == IW'(i));
  end

  mc_rr_arb #(.N(N), .IW(IW)) u_req_arb (
    .clk(clk), .rst_n(rst_n), .req(rq_have), .adv(req_take), .idx(rq_idx), .any(rq_any));
  mc_rr_arb #(.N(N), .IW(IW)) u_rsp_arb (
    .clk(clk), .rst_n(rst_n), .req(rs_have), .adv(rsp_take), .idx(rs_idx), .any(rs_any));

  mc_lane_sel #(.W(W)) u_sel (
    .rsp_have(rs_any), .req_have(rq_any),
    .rsp_msg(rs_head[rs_idx]), .req_msg(rq_head[rq_idx]),
    .rsp_ready(out_rsp_ready), .req_ready(out_req_ready),
    .out_valid(out_valid), .out_is_rsp(out_is_rsp), .out_msg(out_msg),
    .rsp_take(rsp_take), .req_take(req_take));

  assign rsp_pending = |rs_have;
  assign pop_vec     = rq_pop | rs_pop;
endmodule

// File: rtl/mc_channel.sv
module mc_channel #(
  parameter int N_CHILD = 3,
  parameter int DEPTH   = 4,
  parameter int MW      = mc_pkg::MSG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CHILD-1:0]    up_req_valid,
  input  logic [N_CHILD*MW-1:0] up_req_msg,
  output logic [N_CHILD-1:0]    up_req_ready,
  input  logic [N_CHILD-1:0]    up_rsp_valid,
  input  logic [N_CHILD*MW-1:0] up_rsp_msg,
  output logic [N_CHILD-1:0]    up_rsp_ready,
  output logic                  par_valid,
  output logic                  par_is_rsp,
  output logic [MW-1:0]         par_msg,
  input  logic                  par_req_ready,
  input  logic                  par_rsp_ready,
  input  logic                  dn_req_valid,
  input  logic [MW-1:0]         dn_req_msg,
  output logic                  dn_req_ready,
  input  logic                  dn_rsp_valid,
  input  logic [MW-1:0]         dn_rsp_msg,
  output logic                  dn_rsp_ready,
  output logic [N_CHILD-1:0]    ch_valid,
  output logic [N_CHILD-1:0]    ch_is_rsp,
  output logic [N_CHILD*MW-1:0] ch_msg,
  input  logic [N_CHILD-1:0]    ch_req_ready,
  input  logic [N_CHILD-1:0]    ch_rsp_ready
);
  localparam int IDW = mc_pkg::ID_W;

  logic                up_rsp_pending;
  logic [N_CHILD-1:0]  up_pop;
  logic [N_CHILD-1:0]  dn_rsp_pending;
  logic [IDW-1:0]      dreq_dst, drsp_dst;
  logic [N_CHILD-1:0]  dq_rdy, ds_rdy, dq_have, dq_take, ds_take;
  logic [MW-1:0]       dq_head [N_CHILD];
  logic [MW-1:0]       ds_head [N_CHILD];

  mc_merge #(.N(N_CHILD), .DEPTH(DEPTH), .W(MW)) u_up (
    .clk(clk), .rst_n(rst_n),
    .req_valid(up_req_valid), .req_msg(up_req_msg), .req_ready(up_req_ready),
    .rsp_valid(up_rsp_valid), .rsp_msg(up_rsp_msg), .rsp_ready(up_rsp_ready),
    .out_valid(par_valid), .out_is_rsp(par_is_rsp), .out_msg(par_msg),
    .out_req_ready(par_req_ready), .out_rsp_ready(par_rsp_ready),
    .rsp_pending(up_rsp_pending), .pop_vec(up_pop));

  assign dreq_dst = mc_pkg::msg_dst(dn_req_msg);
  assign drsp_dst = mc_pkg::msg_dst(dn_rsp_msg);

  always_comb begin
    dn_req_ready = 1'b0;
    dn_rsp_ready = 1'b0;
    for (int i = 0; i < N_CHILD; i++) begin
      if (dreq_dst == IDW'(i)) dn_req_ready = dq_rdy[i];
      if (drsp_dst == IDW'(i)) dn_rsp_ready = ds_rdy[i];
    end
  end

  for (genvar i = 0; i < N_CHILD; i++) begin : g_dst
    logic req_sel, rsp_sel;
    assign req_sel = dn_req_valid && (dreq_dst == IDW'(i));
    assign rsp_sel = dn_rsp_valid && (drsp_dst == IDW'(i));

    mc_fifo #(.W(MW), .DEPTH(DEPTH)) u_req_q (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_sel), .in_ready(dq_rdy[i]), .in_data(dn_req_msg),
      .out_valid(dq_have[i]), .out_data(dq_head[i]), .pop(dq_take[i]));
    mc_fifo #(.W(MW), .DEPTH(DEPTH)) u_rsp_q (
      .clk(clk), .rst_n(rst_n),
      .in_valid(rsp_sel), .in_ready(ds_rdy[i]), .in_data(dn_rsp_msg),
      .out_valid(dn_rsp_pending[i]), .out_data(ds_head[i]), .pop(ds_take[i]));

    mc_lane_sel #(.W(MW)) u_sel (
      .rsp_have(dn_rsp_pending[i]), .req_have(dq_have[i]),
      .rsp_msg(ds_head[i]), .req_msg(dq_head[i]),
      .rsp_ready(ch_rsp_ready[i]), .req_ready(ch_req_ready[i]),
      .out_valid(ch_valid[i]), .out_is_rsp(ch_is_rsp[i]), .out_msg(ch_msg[i*MW +: MW]),
      .rsp_take(ds_take[i]), .req_take(dq_take[i]));
  end
endmodule

// File: rtl/mc_channel_chk.sv
module mc_channel_chk #(
  parameter int N_CHILD = 3,
  parameter int MW      = mc_pkg::MSG_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               par_valid,
  input logic               par_is_rsp,
  input logic               par_rsp_ready,
  input logic               up_rsp_pending,
  input logic [N_CHILD-1:0] up_pop,
  input logic [N_CHILD-1:0] ch_valid,
  input logic [N_CHILD-1:0] ch_is_rsp,
  input logic [N_CHILD-1:0] dn_rsp_pending,
  input logic               dn_req_valid,
  input logic [MW-1:0]      dn_req_msg,
  input logic               dn_req_ready,
  input logic               dn_rsp_valid,
  input logic [MW-1:0]      dn_rsp_msg,
  input logic               dn_rsp_ready
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!par_valid && ch_valid == '0));

  // R3
  par_rsp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_valid && !par_is_rsp) |-> !up_rsp_pending);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_valid && par_is_rsp && !par_rsp_ready) |=> (par_valid && par_is_rsp));

  // R2
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_pop) && ((up_pop != '0) -> par_valid));

  // R6
  dst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_req_valid && int'(mc_pkg::msg_dst(dn_req_msg)) >= N_CHILD) |-> !dn_req_ready) and
    ((dn_rsp_valid && int'(mc_pkg::msg_dst(dn_rsp_msg)) >= N_CHILD) |-> !dn_rsp_ready));

  for (genvar i = 0; i < N_CHILD; i++) begin : g_c
    // R8
    ch_rsp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid[i] && !ch_is_rsp[i]) |-> !dn_rsp_pending[i]);
  end
endmodule

bind mc_channel mc_channel_chk #(.N_CHILD(N_CHILD), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .par_valid(par_valid), .par_is_rsp(par_is_rsp), .par_rsp_ready(par_rsp_ready),
  .up_rsp_pending(up_rsp_pending), .up_pop(up_pop),
  .ch_valid(ch_valid), .ch_is_rsp(ch_is_rsp), .dn_rsp_pending(dn_rsp_pending),
  .dn_req_valid(dn_req_valid), .dn_req_msg(dn_req_msg), .dn_req_ready(dn_req_ready),
  .dn_rsp_valid(dn_rsp_valid), .dn_rsp_msg(dn_rsp_msg), .dn_rsp_ready(dn_rsp_ready));

// File: tb/test_mc_channel.sv
`timescale 1ns/1ps
module test_mc_channel;
  localparam int N  = 3;
  localparam int D  = 4;
  localparam int MW = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]    up_req_valid = '0, up_rsp_valid = '0;
  logic [N*MW-1:0] up_req_msg = '0, up_rsp_msg = '0;
  logic [N-1:0]    up_req_ready, up_rsp_ready;
  logic            par_valid, par_is_rsp;
  logic [MW-1:0]   par_msg;
  logic            par_req_ready = 1'b0, par_rsp_ready = 1'b0;
  logic            dn_req_valid = 1'b0, dn_rsp_valid = 1'b0;
  logic [MW-1:0]   dn_req_msg = '0, dn_rsp_msg = '0;
  logic            dn_req_ready, dn_rsp_ready;
  logic [N-1:0]    ch_valid, ch_is_rsp;
  logic [N*MW-1:0] ch_msg;
  logic [N-1:0]    ch_req_ready = '0, ch_rsp_ready = '0;

  mc_channel #(.N_CHILD(N), .DEPTH(D)) i_mc_channel (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic [MW-1:0] uq [2][N][$];
  logic [MW-1:0] dq [2][N][$];
  int ulast [2];
  bit            pp_valid, pp_rsp;
  int            pp_idx;
  logic [MW-1:0] pp_msg;
  bit [N-1:0]    pc_valid, pc_rsp;
  logic [MW-1:0] pc_msg [N];
  int par_del [2];
  int par_child_req [N];
  int ch_del [N];
  int seq = 0;
  int p_in = 50, p_prq = 50, p_prs = 50, p_crq = 50, p_crs = 50, stall0 = 0;
  bit no_up_rsp = 0;

  function automatic bit rnd(input int p);
    return int'($urandom % 100) < p;
  endfunction

  function automatic logic [MW-1:0] mk(input int src, input int dst);
    seq++;
    return {2'(src), 2'(dst), 2'($urandom % 3), 8'($urandom % 4), 16'(seq)};
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic model_update();
    bit ua [2][N];
    bit da [2];
    int dd [2];
    for (int i = 0; i < N; i++) begin
      ua[0][i] = up_req_valid[i] && uq[0][i].size() < D;
      ua[1][i] = up_rsp_valid[i] && uq[1][i].size() < D;
    end
    dd[0] = int'(dn_req_msg[27:26]);
    dd[1] = int'(dn_rsp_msg[27:26]);
    da[0] = dn_req_valid && dd[0] < N && dq[0][dd[0] % N].size() < D;
    da[1] = dn_rsp_valid && dd[1] < N && dq[1][dd[1] % N].size() < D;
    if (pp_valid && (pp_rsp ? par_rsp_ready : par_req_ready)) begin
      void'(uq[pp_rsp][pp_idx].pop_front());
      ulast[pp_rsp] = pp_idx;
      par_del[pp_rsp]++;
      if (!pp_rsp) par_child_req[pp_idx]++;
    end
    for (int i = 0; i < N; i++)
      if (pc_valid[i] && (pc_rsp[i] ? ch_rsp_ready[i] : ch_req_ready[i])) begin
        void'(dq[pc_rsp[i]][i].pop_front());
        ch_del[i]++;
      end
    for (int i = 0; i < N; i++) begin
      if (ua[0][i]) uq[0][i].push_back(up_req_msg[i*MW +: MW]);
      if (ua[1][i]) uq[1][i].push_back(up_rsp_msg[i*MW +: MW]);
    end
    if (da[0]) dq[0][dd[0]].push_back(dn_req_msg);
    if (da[1]) dq[1][dd[1]].push_back(dn_rsp_msg);
  endtask

  task automatic predict();
    int cl;
    bit any_rsp;
    any_rsp = 0;
    for (int i = 0; i < N; i++) if (uq[1][i].size() > 0) any_rsp = 1;
    cl = any_rsp ? 1 : 0;
    pp_rsp = any_rsp;
    pp_valid = 0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (ulast[cl] + k) % N;
      if (!pp_valid && uq[cl][c].size() > 0) begin
        pp_valid = 1;
        pp_idx = c;
        pp_msg = uq[cl][c][0];
      end
    end
    for (int i = 0; i < N; i++) begin
      pc_rsp[i] = dq[1][i].size() > 0;
      pc_valid[i] = pc_rsp[i] || dq[0][i].size() > 0;
      if (pc_valid[i]) pc_msg[i] = pc_rsp[i] ? dq[1][i][0] : dq[0][i][0];
    end
  endtask

  task automatic compare();
    int d0, d1;
    chk("R2 par_valid", 64'(par_valid), 64'(pp_valid));
    if (pp_valid) begin
      chk("R3 par_is_rsp", 64'(par_is_rsp), 64'(pp_rsp));
      chk("R4 par_msg order/rotation", 64'(par_msg), 64'(pp_msg));
    end
    for (int i = 0; i < N; i++) begin
      chk("R5 up_req_ready", 64'(up_req_ready[i]), 64'(uq[0][i].size() < D));
      chk("R5 up_rsp_ready", 64'(up_rsp_ready[i]), 64'(uq[1][i].size() < D));
      chk("R7 ch_valid", 64'(ch_valid[i]), 64'(pc_valid[i]));
      if (pc_valid[i]) begin
        chk("R8 ch_is_rsp", 64'(ch_is_rsp[i]), 64'(pc_rsp[i]));
        chk("R7 ch_msg", 64'(ch_msg[i*MW +: MW]), 64'(pc_msg[i]));
      end
    end
    d0 = int'(dn_req_msg[27:26]);
    d1 = int'(dn_rsp_msg[27:26]);
    chk("R6 dn_req_ready", 64'(dn_req_ready), 64'(d0 < N && dq[0][d0 % N].size() < D));
    chk("R6 dn_rsp_ready", 64'(dn_rsp_ready), 64'(d1 < N && dq[1][d1 % N].size() < D));
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      up_req_valid[i] = rnd(p_in);
      up_rsp_valid[i] = !no_up_rsp && rnd(p_in);
      up_req_msg[i*MW +: MW] = mk(i, 3);
      up_rsp_msg[i*MW +: MW] = mk(i, 3);
      ch_req_ready[i] = (stall0 != 0 && i == 0) ? 1'b0 : rnd(p_crq);
      ch_rsp_ready[i] = (stall0 != 0 && i == 0) ? 1'b0 : rnd(p_crs);
    end
    dn_req_valid = rnd(p_in);
    dn_rsp_valid = rnd(p_in);
    dn_req_msg = mk(3, int'($urandom % 4));
    dn_rsp_msg = mk(3, int'($urandom % 4));
    par_req_ready = rnd(p_prq);
    par_rsp_ready = rnd(p_prs);
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      model_update();
      predict();
      compare();
      drive();
    end
  endtask

  initial begin
    ulast[0] = N - 1;
    ulast[1] = N - 1;
    pp_valid = 0;
    pc_valid = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs and open inputs while in reset
    chk("R1 par_valid", 64'(par_valid), 64'd0);
    chk("R1 ch_valid", 64'(ch_valid), 64'd0);
    chk("R1 up_req_ready", 64'(up_req_ready), 64'((1 << N) - 1));
    chk("R1 up_rsp_ready", 64'(up_rsp_ready), 64'((1 << N) - 1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 par_valid after release", 64'(par_valid), 64'd0);

    run(600);

    // R9: requests stalled everywhere, responses must keep moving
    p_prq = 0; p_crq = 0; p_prs = 100; p_crs = 100;
    run(20);
    par_del[0] = 0; par_del[1] = 0;
    run(300);
    chk("R9 requests held at parent", 64'(par_del[0]), 64'd0);
    chk("R9 responses flowing", 64'(par_del[1] > 100), 64'd1);

    // R3: responses held, requests must wait behind them
    p_prq = 100; p_crq = 100; p_prs = 0; p_crs = 0;
    run(300);

    // R4: saturated requests only, equal share per child
    p_in = 100; no_up_rsp = 1; p_prq = 100; p_prs = 100; p_crq = 100; p_crs = 100;
    run(30);
    for (int i = 0; i < N; i++) par_child_req[i] = 0;
    run(60);
    for (int i = 0; i < N; i++) chk("R4 round-robin share", 64'(par_child_req[i]), 64'd20);

    // R10: child 0 fully stalled, others continue
    no_up_rsp = 0; p_in = 60; stall0 = 1;
    run(20);
    for (int i = 0; i < N; i++) ch_del[i] = 0;
    run(200);
    chk("R10 stalled child idle", 64'(ch_del[0]), 64'd0);
    chk("R10 child 1 served", 64'(ch_del[1] > 0), 64'd1);
    chk("R10 child 2 served", 64'(ch_del[2] > 0), 64'd1);

    stall0 = 0; p_in = 50; p_prq = 50; p_prs = 50; p_crq = 50; p_crs = 50;
    run(600);

    // R2: drain, nothing left behind
    p_in = 0; p_prq = 100; p_prs = 100; p_crq = 100; p_crs = 100;
    run(60);
    chk("R2 parent drained", 64'(par_valid), 64'd0);
    chk("R7 children drained", 64'(ch_valid), 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule